// File: doc/BRIEF.md
# DRAM Page Hit Detector

This block sits beside an external memory bus interface and decides, for each external access, whether the access stays in the DRAM row that is already open. When it does, a memory controller can use the fast page or static column cycle and finish the access with no wait states. When it does not, the controller has to precharge and open a new row.

The block sees each bus cycle as a valid strobe together with the address and a two-bit memory space code. Three of the four space codes are real memory spaces, and each of the three has its own enable bit. The page of an access is the group of address bits above a column-width boundary that is set by a parameter. A mask input chooses which of those page bits take part in the compare, so one build can serve DRAMs of different row sizes. The verdict is registered and appears on an active-low transfer-type output one clock after the access. The output is low for a page hit and high for a page fault. It is also high whenever the access is not checked.

The block holds one stored page and one page-valid flag. Every checked access loads its page into the store. The flag is cleared by reset and by loss of bus mastership, so the first checked access after either event is always reported as a fault.

Top module: `pg_hit_detect`

## Requirements
- R1: After reset `tt_n` is 1 and no page is open. The first checked access after reset yields `tt_n` = 1 one cycle later.
- R2: A checked access whose masked page equals the stored page, while a page is open, drives `tt_n` to 0 in the next cycle.
- R3: A checked access whose masked page differs from the stored page drives `tt_n` to 1 in the next cycle.
- R4: An access to an enabled-capable space whose enable bit is 0 gives `tt_n` = 1 in the next cycle and leaves the stored page and the valid flag unchanged.
- R5: Space code 2'b11 is never checked. It gives `tt_n` = 1 and leaves the stored page unchanged.
- R6: While `is_master` is 0, `tt_n` is 1 in the next cycle and the open page is dropped. The first checked access after mastership returns is a fault.
- R7: A cycle with `cyc_valid` = 0 gives `tt_n` = 1 in the next cycle and does not change the stored page.
- R8: Page bits are `bus_addr[ADDR_W-1:COL_W]`. Page bit i takes part in the compare only when `page_mask[i]` = 1. Column bits never take part.
- R9: Every checked access loads its own page, hit or fault, so the next access is compared against the most recent one.
- R10: Space code 2'b00 uses `space_en[0]`, 2'b01 uses `space_en[1]`, and 2'b10 uses `space_en[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Address of the current bus cycle |
| mem_space | input | 2 | Memory space code of the cycle |
| is_master | input | 1 | High while this device owns the bus |
| cyc_valid | input | 1 | Marks a bus cycle in progress this clock |
| space_en | input | 3 | Per-space check enable, bit index = space code |
| page_mask | input | ADDR_W-COL_W | Selects the page bits used in the compare |
| tt_n | output | 1 | Registered transfer type, 0 = page hit |

## Verification
The bench builds the detector with an 8-bit address and a 4-bit column field, which leaves a 4-bit page. With that width, every address can be swept in every space under all eight enable patterns. Every pair of pages can also be tried under all sixteen masks. Together these sweeps reach every hit and fault case, every enable and space combination, and every mask bit. Directed sequences then cover loss of mastership, idle cycles and reset in the middle of a run.

// File: rtl/pg_pkg.sv
package pg_pkg;

    localparam int NUM_SPACES = 3;

    typedef enum logic [1:0] {
        SP_LOW  = 2'b00,
        SP_MID  = 2'b01,
        SP_HIGH = 2'b10,
        SP_NONE = 2'b11
    } space_e;

    typedef struct packed {
        logic monitor;
        logic hit;
    } pg_verdict_t;

    function automatic logic space_checked(input logic [1:0] sp,
                                           input logic [NUM_SPACES-1:0] en);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_SPACES; i++) begin
            if (sp == 2'(i)) r = en[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/pg_space_gate.sv
module pg_space_gate
    import pg_pkg::*;
(
    input  logic                  cyc_valid,
    input  logic                  is_master,
    input  logic [1:0]            mem_space,
    input  logic [NUM_SPACES-1:0] space_en,
    output logic                  monitor
);
    logic [NUM_SPACES-1:0] sel;

    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_sel
        assign sel[g] = (mem_space == 2'(g)) && space_en[g];
    end

    assign monitor = cyc_valid && is_master && (|sel);
endmodule

// File: rtl/pg_page_store.sv
module pg_page_store #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drop,
    input  logic              load,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [PAGE_W-1:0] mask,
    output logic              hit
);
    logic [PAGE_W-1:0] open_page;
    logic              open_vld;
    logic [PAGE_W-1:0] diff;

    for (genvar b = 0; b < PAGE_W; b++) begin : g_cmp
        assign diff[b] = mask[b] && (page_in[b] != open_page[b]);
    end

    assign hit = open_vld && (diff == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_page <= '0;
            open_vld  <= 1'b0;
        end else if (drop) begin
            open_vld  <= 1'b0;
        end else if (load) begin
            open_page <= page_in;
            open_vld  <= 1'b1;
        end
    end
endmodule

// File: rtl/pg_hit_detect.sv
module pg_hit_detect
    import pg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int COL_W  = 10,
    localparam int PAGE_W = ADDR_W - COL_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [1:0]            mem_space,
    input  logic                  is_master,
    input  logic                  cyc_valid,
    input  logic [NUM_SPACES-1:0] space_en,
    input  logic [PAGE_W-1:0]     page_mask,
    output logic                  tt_n
);
    pg_verdict_t verdict;
    logic        unused_col;

    assign unused_col = ^bus_addr[COL_W-1:0];

    pg_space_gate u_gate (
        .cyc_valid (cyc_valid),
        .is_master (is_master),
        .mem_space (mem_space),
        .space_en  (space_en),
        .monitor   (verdict.monitor)
    );

    pg_page_store #(.PAGE_W(PAGE_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .drop    (!is_master),
        .load    (verdict.monitor),
        .page_in (bus_addr[ADDR_W-1:COL_W]),
        .mask    (page_mask),
        .hit     (verdict.hit)
    );

    always_ff @(posedge clk) begin
        if (rst) tt_n <= 1'b1;
        else     tt_n <= !(verdict.monitor && verdict.hit);
    end
endmodule

// File: rtl/pg_hit_detect_chk.sv
module pg_hit_detect_chk
    import pg_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [1:0]            mem_space,
    input logic                  is_master,
    input logic                  cyc_valid,
    input logic [NUM_SPACES-1:0] space_en,
    input logic                  tt_n
);
    logic seen;
    logic checked;

    assign checked = cyc_valid && is_master && space_checked(mem_space, space_en);

    always_ff @(posedge clk) begin
        if (rst || !is_master) seen <= 1'b0;
        else if (checked)      seen <= 1'b1;
    end

    p_first_fault_r1: assert property (@(posedge clk) disable iff (rst)
        checked && !seen |=> tt_n);
    p_disabled_high_r4: assert property (@(posedge clk) disable iff (rst)
        cyc_valid && mem_space != 2'b11 && !space_checked(mem_space, space_en) |=> tt_n);
    p_space3_high_r5: assert property (@(posedge clk) disable iff (rst)
        cyc_valid && mem_space == 2'b11 |=> tt_n);
    p_slave_high_r6: assert property (@(posedge clk) disable iff (rst)
        !is_master |=> tt_n);
    p_idle_high_r7: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |=> tt_n);
endmodule

bind pg_hit_detect pg_hit_detect_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_space (mem_space),
    .is_master (is_master),
    .cyc_valid (cyc_valid),
    .space_en  (space_en),
    .tt_n      (tt_n)
);

// File: tb/tb_pg_hit_detect.sv
`timescale 1ns/1ps
module tb_pg_hit_detect;
    localparam int AW = 8;
    localparam int CW = 4;
    localparam int PW = AW - CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    mem_space = 2'b00;
    logic          is_master = 1'b0;
    logic          cyc_valid = 1'b0;
    logic [2:0]    space_en = 3'b000;
    logic [PW-1:0] page_mask = '1;
    logic          tt_n;

    int checks = 0;
    int errors = 0;
    logic          rv = 1'b0;
    logic [PW-1:0] rp = '0;

    always #5 clk = ~clk;

    pg_hit_detect #(.ADDR_W(AW), .COL_W(CW)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .mem_space(mem_space),
        .is_master(is_master), .cyc_valid(cyc_valid), .space_en(space_en),
        .page_mask(page_mask), .tt_n(tt_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: tt_n=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [AW-1:0] a, input logic [1:0] sp,
                       input logic m, input logic v, input string force_tag);
        logic mon, hitx, exp;
        string tag;
        bus_addr = a; mem_space = sp; is_master = m; cyc_valid = v;
        mon  = v && m && sp != 2'b11 && space_en[sp];
        hitx = rv && (((a[AW-1:CW] ^ rp) & page_mask) == '0);
        exp  = !(mon && hitx);
        if (!v)               tag = "R7";
        else if (!m)          tag = "R6";
        else if (sp == 2'b11) tag = "R5";
        else if (!mon)        tag = "R4";
        else if (!rv)         tag = "R1";
        else if (hitx)        tag = "R2";
        else                  tag = "R3";
        if (force_tag != "") tag = force_tag;
        if (!m) rv = 1'b0;
        else if (mon) begin rp = a[AW-1:CW]; rv = 1'b1; end
        @(negedge clk);
        check(tag, tt_n, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1; cyc_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0; rv = 1'b0; rp = '0;
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog: tt_n=%0b expected end of run", tt_n);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1", tt_n, 1'b1);

        // R1: first checked access after reset faults, second hits
        space_en = 3'b111;
        cyc(8'h35, 2'b01, 1, 1, "R1");
        cyc(8'h3A, 2'b01, 1, 1, "R2");

        // Sweep enables x spaces x all addresses (R2 R3 R4 R5 R10)
        for (int e = 0; e < 8; e++) begin
            space_en = 3'(e);
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 256; a++)
                    cyc(8'(a), 2'(s), 1, 1, "");
        end

        // R10: enable bit index follows space code
        space_en = 3'b010;
        cyc(8'h70, 2'b01, 1, 1, "R10");
        cyc(8'h71, 2'b00, 1, 1, "R10");
        cyc(8'h72, 2'b01, 1, 1, "R10");
        space_en = 3'b100;
        cyc(8'h90, 2'b10, 1, 1, "R10");
        cyc(8'h91, 2'b10, 1, 1, "R10");

        // R8: mask sweep over every page pair
        space_en = 3'b111;
        for (int mk = 0; mk < 16; mk++) begin
            page_mask = 4'(mk);
            for (int p1 = 0; p1 < 16; p1++)
                for (int p2 = 0; p2 < 16; p2++) begin
                    cyc({4'(p1), 4'(p2)}, 2'b00, 1, 1, "R8");
                    cyc({4'(p2), 4'(p1)}, 2'b10, 1, 1, "R8");
                end
        end
        page_mask = '1;

        // R9: page follows most recent checked access
        cyc(8'h20, 2'b00, 1, 1, "R9");
        cyc(8'h50, 2'b00, 1, 1, "R9");
        cyc(8'h20, 2'b00, 1, 1, "R9");
        cyc(8'h2F, 2'b00, 1, 1, "R9");

        // R6: mastership loss drops page
        cyc(8'hC0, 2'b01, 1, 1, "R6");
        cyc(8'hC1, 2'b01, 0, 1, "R6");
        cyc(8'hC2, 2'b01, 0, 0, "R6");
        cyc(8'hC3, 2'b01, 1, 1, "R6");
        cyc(8'hC4, 2'b01, 1, 1, "R6");

        // R7: idle cycles do not move the page
        cyc(8'hE0, 2'b00, 1, 0, "R7");
        cyc(8'hC5, 2'b00, 1, 1, "R7");

        // R5: space 11 does not move the page
        cyc(8'h10, 2'b11, 1, 1, "R5");
        cyc(8'hC6, 2'b10, 1, 1, "R5");

        // R4: disabled space does not move the page
        space_en = 3'b011;
        cyc(8'h80, 2'b10, 1, 1, "R4");
        cyc(8'hC7, 2'b00, 1, 1, "R4");

        // R1: reset mid-run closes the page
        do_reset();
        check("R1", tt_n, 1'b1);
        cyc(8'hC8, 2'b00, 1, 1, "R1");
        cyc(8'hC9, 2'b00, 1, 1, "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule